// File: doc/BRIEF.md
# Serial Write Port Controller

This block is the write half of a serial field store. On every rising edge of the write clock it looks at a write-enable level and a 4-bit data nibble. Enabled nibbles are placed at the current write pointer, and the pointer then moves on by one. A separate write-reset input, checked on the same edge, sends the pointer back to zero. That is how a new field starts.

Nibbles are not sent to storage one by one. They collect in an 8-entry staging line, and the line goes to the storage array as a single wide write, with a base address, a packed data word and a per-entry valid mask. A line goes out when its last entry is filled. It also goes out on a write reset, so the tail of a field that stops partway through a line still reaches storage.

The port is fully static: the enable may stay low for any length of time without losing anything. Two sticky flags report misuse. One flags a reset that comes back too soon after the previous one. The other flags a field that held too few enabled writes before the next reset.

Top module: `fld_wr_port`

## Requirements
- R1: The first rising clock edge that samples `wr_rst_i` high (after a sample of it low) sets `wptr_o` to zero, visible after that edge. Every further edge that samples `wr_rst_i` high also leaves `wptr_o` at zero.
- R2: On any edge that samples `wr_rst_i` high, `wr_en_i` is ignored. No nibble is staged and the pointer does not advance.
- R3: On an edge with `wr_rst_i` low and `wr_en_i` high, `din_i` is staged at entry `wptr_o[2:0]` of the current line, and `wptr_o` increments by one.
- R4: On an edge with `wr_rst_i` and `wr_en_i` both low, `wptr_o` and the staged data hold their values, however many such edges occur.
- R5: When entry 7 of a line is written, `arr_we_o` is high for exactly the following cycle. In that cycle `arr_addr_o` is the line base (pointer with bits [2:0] cleared), `arr_mask_o` is 8'hFF, and `arr_data_o[4*i+3:4*i]` holds the nibble of entry i.
- R6: A reset edge (rising, as in R1) that finds a partly filled line flushes it. `arr_we_o` pulses in the next cycle. `arr_mask_o` bit i is set only for the written entries, and unwritten lanes of `arr_data_o` read zero. A reset that finds the line empty produces no strobe.
- R7: The pointer is `AW` bits wide and wraps from 2**AW-1 to 0 on an enabled write.
- R8: `err_rearm_o` becomes set, and stays set until `rst_n` is applied, when a reset edge comes after fewer than 2 edges with `wr_rst_i` low since it was last sampled high.
- R9: `err_short_o` becomes set, and stays set until `rst_n` is applied, when a reset edge follows an earlier reset edge with fewer than 130 enabled writes between them. The first reset after `rst_n` never sets it.
- R10: While `rst_n` is low, `wptr_o` is 0, `arr_we_o` is 0, both error flags are 0 and the staging line is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_rst_i | input | 1 | Field start: return pointer to zero |
| wr_en_i | input | 1 | Write enable for the sampled nibble |
| din_i | input | 4 | Data nibble |
| arr_we_o | output | 1 | Array write strobe, one cycle per line |
| arr_addr_o | output | AW | Base address of the line being written |
| arr_data_o | output | 32 | Packed line data, entry i at bits 4i+3:4i |
| arr_mask_o | output | 8 | Valid mask of the line entries |
| wptr_o | output | AW | Current write pointer |
| err_rearm_o | output | 1 | Sticky: reset re-asserted too soon |
| err_short_o | output | 1 | Sticky: field shorter than the minimum |

## Verification
The bench goes after the reset edge that arrives with enable high: a design that honours the enable there would stage a nibble and send a pointer of 1, not 0, into the next field. It also checks the partial-line flush on reset. Without it, the tail nibbles of a field would never reach storage, and a wrong mask would show up as corrupted lanes. The pointer is driven across its wrap and held through long idle gaps, which exposes an off-by-one line base or a pointer that drifts while the enable is low. Finally, resets are placed at exactly one and two low cycles apart, and fields are made just shorter and just longer than the minimum, to catch flags that are set at the wrong threshold or that are not sticky.

// File: rtl/fld_wr_port.sv
module fld_wr_port #(
  parameter int AW      = 10,
  parameter int DW      = 4,
  parameter int LINE    = 8,
  parameter int MIN_RUN = 130,
  parameter int GAP     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_rst_i,
  input  logic                 wr_en_i,
  input  logic [DW-1:0]        din_i,
  output logic                 arr_we_o,
  output logic [AW-1:0]        arr_addr_o,
  output logic [LINE*DW-1:0]   arr_data_o,
  output logic [LINE-1:0]      arr_mask_o,
  output logic [AW-1:0]        wptr_o,
  output logic                 err_rearm_o,
  output logic                 err_short_o
);
  localparam int LW = $clog2(LINE);
  localparam int CW = $clog2(MIN_RUN + 1);
  localparam int GW = $clog2(GAP + 1);

  logic                rst_q, seen;
  logic [GW-1:0]       low_cnt;
  logic [CW-1:0]       run_cnt;
  logic [AW-1:0]       ptr;
  logic [LINE*DW-1:0]  stg, stg_nxt;
  logic [LINE-1:0]     vld, vld_nxt;

  wire          rst_edge = wr_rst_i & ~rst_q;
  wire          wr       = wr_en_i & ~wr_rst_i;
  wire [LW-1:0] slot     = ptr[LW-1:0];
  wire          full     = wr & (slot == LW'(LINE - 1));
  wire [AW-1:0] base     = {ptr[AW-1:LW], {LW{1'b0}}};

  assign wptr_o = ptr;

  always_comb begin
    stg_nxt = stg;
    vld_nxt = vld;
    if (wr) begin
      stg_nxt[int'(slot)*DW +: DW] = din_i;
      vld_nxt[slot] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q       <= 1'b0;
      seen        <= 1'b0;
      low_cnt     <= GW'(GAP);
      run_cnt     <= '0;
      ptr         <= '0;
      stg         <= '0;
      vld         <= '0;
      arr_we_o    <= 1'b0;
      arr_addr_o  <= '0;
      arr_data_o  <= '0;
      arr_mask_o  <= '0;
      err_rearm_o <= 1'b0;
      err_short_o <= 1'b0;
    end else begin
      rst_q    <= wr_rst_i;
      arr_we_o <= 1'b0;
      if (wr_rst_i) begin
        ptr     <= '0;
        low_cnt <= '0;
      end else if (low_cnt != GW'(GAP)) begin
        low_cnt <= low_cnt + 1'b1;
      end
      if (wr) begin
        ptr <= ptr + 1'b1;
        if (run_cnt != CW'(MIN_RUN)) run_cnt <= run_cnt + 1'b1;
      end
      if (rst_edge) begin
        if (low_cnt < GW'(GAP)) err_rearm_o <= 1'b1;
        if (seen && run_cnt < CW'(MIN_RUN)) err_short_o <= 1'b1;
        seen    <= 1'b1;
        run_cnt <= '0;
        if (|vld) begin
          arr_we_o   <= 1'b1;
          arr_addr_o <= base;
          arr_data_o <= stg;
          arr_mask_o <= vld;
        end
        stg <= '0;
        vld <= '0;
      end else if (full) begin
        arr_we_o   <= 1'b1;
        arr_addr_o <= base;
        arr_data_o <= stg_nxt;
        arr_mask_o <= vld_nxt;
        stg        <= '0;
        vld        <= '0;
      end else begin
        stg <= stg_nxt;
        vld <= vld_nxt;
      end
    end
  end

  assert_ptr_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst_i |=> (wptr_o == '0));
  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_rst_i) |=> (wptr_o == $past(wptr_o) + 1'b1));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !wr_rst_i) |=> $stable(wptr_o));
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |=> !arr_we_o);
  assert_mask_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> (arr_mask_o != '0));
  assert_rearm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_rearm_o |=> err_rearm_o);
  assert_short_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_short_o |=> err_short_o);
  assert_short_on_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_short_o) |-> $past(wr_rst_i));
endmodule

// File: tb/sim_fld_wr_port.sv
module sim_fld_wr_port;
  localparam int AW = 10;
  localparam int DW = 4;
  localparam int LINE = 8;
  localparam int MIN_RUN = 130;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_rst_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [DW-1:0] din_i = '0;
  logic arr_we_o;
  logic [AW-1:0] arr_addr_o;
  logic [LINE*DW-1:0] arr_data_o;
  logic [LINE-1:0] arr_mask_o;
  logic [AW-1:0] wptr_o;
  logic err_rearm_o, err_short_o;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  fld_wr_port #(.AW(AW), .DW(DW), .LINE(LINE), .MIN_RUN(MIN_RUN), .GAP(2)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_rst_i(wr_rst_i), .wr_en_i(wr_en_i), .din_i(din_i),
    .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o),
    .arr_mask_o(arr_mask_o), .wptr_o(wptr_o), .err_rearm_o(err_rearm_o),
    .err_short_o(err_short_o));

  logic [AW-1:0]      q_addr[$];
  logic [LINE*DW-1:0] q_data[$];
  logic [LINE-1:0]    q_mask[$];

  logic [AW-1:0]      m_ptr;
  logic [LINE*DW-1:0] m_buf;
  logic [LINE-1:0]    m_mask;
  logic               m_rstq, m_seen, e_rearm, e_short;
  int                 m_low, m_cnt;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_ptr = '0; m_buf = '0; m_mask = '0; m_rstq = 1'b0; m_seen = 1'b0;
    e_rearm = 1'b0; e_short = 1'b0; m_low = 2; m_cnt = 0;
    q_addr.delete(); q_data.delete(); q_mask.delete();
  endtask

  task automatic push_line();
    q_addr.push_back({m_ptr[AW-1:3], 3'b000});
    q_data.push_back(m_buf);
    q_mask.push_back(m_mask);
    m_buf = '0; m_mask = '0;
  endtask

  task automatic step(input logic r, input logic e, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    wr_rst_i = r; wr_en_i = e; din_i = d;
    if (r) begin
      if (!m_rstq) begin
        if (m_low < 2) e_rearm = 1'b1;
        if (m_seen && m_cnt < MIN_RUN) e_short = 1'b1;
        if (m_mask != '0) push_line();
        m_seen = 1'b1; m_cnt = 0;
      end
      m_ptr = '0; m_low = 0;
    end else begin
      if (m_low < 2) m_low++;
      if (e) begin
        m_buf[int'(m_ptr[2:0])*DW +: DW] = d;
        m_mask[m_ptr[2:0]] = 1'b1;
        if (m_ptr[2:0] == 3'd7) push_line();
        m_ptr = m_ptr + 1'b1;
        if (m_cnt < MIN_RUN) m_cnt++;
      end
    end
    m_rstq = r;
    @(posedge clk); #2;
    chk(tag, 64'(wptr_o), 64'(m_ptr));
    chk("R8", 64'(err_rearm_o), 64'(e_rearm));
    chk("R9", 64'(err_short_o), 64'(e_short));
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && arr_we_o) begin
      if (q_addr.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 actual=unexpected strobe expected=no strobe at %0t", $time);
      end else begin
        chk("R5", 64'(arr_addr_o), 64'(q_addr.pop_front()));
        chk("R5", 64'(arr_data_o), 64'(q_data.pop_front()));
        chk("R6", 64'(arr_mask_o), 64'(q_mask.pop_front()));
      end
    end
  end

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #2;
    chk("R10", 64'(wptr_o), 0);
    chk("R10", 64'(arr_we_o), 0);
    chk("R10", 64'({err_rearm_o, err_short_o}), 0);
    rst_n = 1'b1;

    step(1, 0, 0, "R1");
    step(0, 0, 0, "R4");
    step(0, 0, 0, "R4");
    for (int i = 0; i < 140; i++) begin
      step(0, 1, DW'(i * 7 + 3), "R3");
      if (i % 37 == 5) for (int k = 0; k < 9; k++) step(0, 0, 4'hF, "R4");
    end
    // field of 140 writes: no short flag (R9); partial line of 4 flushed (R6); enable ignored (R2)
    step(1, 1, 4'hA, "R2");
    step(1, 1, 4'h5, "R1");
    step(0, 0, 0, "R4");
    step(0, 0, 0, "R4");
    for (int i = 0; i < 3; i++) step(0, 1, DW'(i + 9), "R3");
    step(0, 0, 0, "R4");
    // only one low cycle before re-assert: rearm error (R8), short field (R9)
    step(1, 0, 0, "R1");
    step(0, 1, 4'h6, "R3");
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R4");
    repeat (3) @(posedge clk);
    #2;
    chk("R6", 64'(q_addr.size()), 0);

    rst_n = 1'b0;
    @(negedge clk);
    model_clear();
    #1;
    chk("R10", 64'(wptr_o), 0);
    chk("R10", 64'({err_rearm_o, err_short_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R4");
    step(0, 0, 0, "R4");
    for (int i = 0; i < (1 << AW) + 3; i++) step(0, 1, DW'(i ^ (i >> 4)), "R7");
    chk("R7", 64'(wptr_o), 3);
    for (int i = 0; i < 5; i++) step(0, 1, DW'(i), "R3");
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R4");
    step(0, 0, 0, "R4");
    // empty line on reset: no strobe (R6)
    step(1, 0, 0, "R6");
    step(0, 0, 0, "R4");
    repeat (3) @(posedge clk);
    #2;
    chk("R5", 64'(q_addr.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule